// File: doc/BRIEF.md
# Programmable Raster Display Timing Generator

This block sequences the horizontal and vertical timing of a raster display panel. It runs on a system clock and advances one pixel position for each one-cycle rising-edge strobe of the pixel clock. A second strobe marks the falling edge of the pixel clock. Each line and each frame is split into four segments, and every segment length comes from a parameter input. From these the block drives a line sync, a frame sync, an active-area enable and a slow alternating bias signal. It also gives the zero-based column and row of the active pixel. A one-cycle request pulse tells an upstream pixel source to present the data for that position.

Each sync output can be launched on either pixel-clock edge and can be inverted on its own. The timing parameters are sampled from the inputs into a shadow copy. This happens in the cycles after reset up to the first pixel strobe, and again when the final pixel of a frame is left. Software may therefore rewrite the parameters at any time without corrupting the frame in progress.

Top module: `lcd_raster_timer`

## Requirements
- R1: After reset, hsync and vsync sit at their inactive level (0 when the invert inputs are 0). de, pix_req, ac_bias, col and row are all 0.
- R2: Each line is built from four pixel segments in this order: sync (hs_len+1 pixels, with the raw line sync asserted), back porch (hb_len+1), active (ha_len+1), front porch (hf_len+1). The line period is the sum of the four.
- R3: Each frame is built from four line segments in this order: sync (vs_len+1 lines, with the raw frame sync asserted for every pixel of those lines), back porch (vb_len+1), active (va_len+1), front porch (vf_len+1). The first pixel after reset is pixel 0 of line 0, and that line opens both syncs.
- R4: de is 1 exactly while the current pixel lies in both the active pixel segment and the active line segment. col then counts 0..ha_len and row counts 0..va_len. Outside the active area, col and row are 0.
- R5: pix_req is high for one clock, in the cycle after each pix_rise strobe that begins an active pixel. In that same cycle de, col and row already show that pixel.
- R6: With hs_on_fall (or vs_on_fall) = 0, the sync level for a new pixel appears in the cycle after its pix_rise strobe. With the select = 1, it appears only in the cycle after the next pix_fall strobe, and until then it keeps the previous pixel's level.
- R7: hs_invert and vs_invert invert their outputs right away, with no strobe needed. The level 1 on an invert input gives an active-low sync.
- R8: ac_bias starts at 0 and inverts once for every acb_len+1 completed lines. With acb_len = 0 it inverts at every line start.
- R9: Parameter input changes have no effect until the frame in progress ends. The new values then govern the whole next frame.
- R10: With no pix_rise strobe, position and outputs do not advance. In particular, a pix_fall strobe never moves the position.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pix_rise | input | 1 | One-cycle strobe: pixel-clock rising edge |
| pix_fall | input | 1 | One-cycle strobe: pixel-clock falling edge |
| cfg_hs_len | input | H_W | Line sync width minus one |
| cfg_hb_len | input | H_W | Line back porch minus one |
| cfg_ha_len | input | H_W | Active pixels per line minus one |
| cfg_hf_len | input | H_W | Line front porch minus one |
| cfg_vs_len | input | V_W | Frame sync width in lines minus one |
| cfg_vb_len | input | V_W | Frame back porch in lines minus one |
| cfg_va_len | input | V_W | Active lines per frame minus one |
| cfg_vf_len | input | V_W | Frame front porch in lines minus one |
| cfg_acb_len | input | ACB_W | Lines between bias inversions minus one |
| hs_on_fall | input | 1 | Launch line sync on falling strobe |
| vs_on_fall | input | 1 | Launch frame sync on falling strobe |
| hs_invert | input | 1 | Active-low line sync |
| vs_invert | input | 1 | Active-low frame sync |
| hsync | output | 1 | Line sync |
| vsync | output | 1 | Frame sync |
| ac_bias | output | 1 | Alternating panel bias |
| de | output | 1 | Active-area enable |
| pix_req | output | 1 | Pixel data request pulse |
| col | output | H_W | Active column, zero-based |
| row | output | V_W | Active row, zero-based |

## Verification
The bench compares every pixel of several frames against a position model built from the segment lengths. This catches a segment that is off by one in its length, or segments that come in the wrong order: either one shifts the sync edges and the de window. Zero-length parameter fields and mixed edge selects are tested. A design that launched on the wrong edge would show the new sync level one strobe too early or too late. A mid-frame parameter rewrite is applied and then followed into the next frame, which exposes a design that splits a frame between two settings. Idle stretches and lone falling strobes show whether position creeps forward without a rising strobe. The bias inversion count, checked with periods of one and three lines, catches off-by-one line intervals.

// File: rtl/lcd_raster_pkg.sv
package lcd_raster_pkg;

    // Segment order within a line (pixels) or within a frame (lines).
    typedef enum logic [1:0] {
        SEG_SYNC  = 2'd0,
        SEG_BACK  = 2'd1,
        SEG_SHOW  = 2'd2,
        SEG_FRONT = 2'd3
    } seg_e;

    function automatic seg_e seg_after(input seg_e s);
        case (s)
            SEG_SYNC:  return SEG_BACK;
            SEG_BACK:  return SEG_SHOW;
            SEG_SHOW:  return SEG_FRONT;
            default:   return SEG_SYNC;
        endcase
    endfunction

endpackage

// File: rtl/lcd_axis_seq.sv
// Four-segment position counter used for both the pixel and the line axis.
module lcd_axis_seq
    import lcd_raster_pkg::*;
#(
    parameter int W = 10
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         step,
    input  logic [W-1:0] len_sync,
    input  logic [W-1:0] len_back,
    input  logic [W-1:0] len_show,
    input  logic [W-1:0] len_front,
    output seg_e         seg_q,
    output seg_e         seg_d,
    output logic [W-1:0] idx_d,
    output logic         last
);

    typedef struct packed {
        seg_e         seg;
        logic [W-1:0] idx;
    } pos_t;

    pos_t         pos_q, pos_d;
    logic [W-1:0] span;

    always_comb begin
        case (pos_q.seg)
            SEG_SYNC: span = len_sync;
            SEG_BACK: span = len_back;
            SEG_SHOW: span = len_show;
            default:  span = len_front;
        endcase
        last  = (pos_q.seg == SEG_FRONT) && (pos_q.idx >= span);
        pos_d = pos_q;
        if (step) begin
            if (pos_q.idx >= span) begin
                pos_d.idx = '0;
                pos_d.seg = seg_after(pos_q.seg);
            end else begin
                pos_d.idx = pos_q.idx + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pos_q <= '{seg: SEG_SYNC, idx: '0};
        end else begin
            pos_q <= pos_d;
        end
    end

    assign seg_q = pos_q.seg;
    assign seg_d = pos_d.seg;
    assign idx_d = pos_d.idx;

    // Segment lengths hold for pixels (R2) and lines (R3).
    assert_idx_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
        pos_q.idx <= span);

    assert_hold_no_step_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !step |=> (pos_q == $past(pos_q)));

endmodule

// File: rtl/lcd_sync_launch.sv
// Edge-selectable, polarity-selectable sync output stage.
module lcd_sync_launch (
    input  logic clk,
    input  logic rst_n,
    input  logic rise,
    input  logic fall,
    input  logic on_fall,
    input  logic invert,
    input  logic lvl_next,
    input  logic lvl_now,
    output logic sync
);

    logic lvl_q, lvl_d;

    always_comb begin
        lvl_d = lvl_q;
        if (on_fall) begin
            if (fall) lvl_d = lvl_now;
        end else if (rise) begin
            lvl_d = lvl_next;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) lvl_q <= 1'b0;
        else        lvl_q <= lvl_d;
    end

    assign sync = lvl_q ^ invert;

    assert_launch_edge_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(lvl_q) |-> $past(on_fall ? fall : rise));

endmodule

// File: rtl/lcd_acb_toggle.sv
// Alternating bias: inverts after a programmable number of lines.
module lcd_acb_toggle #(
    parameter int ACB_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             line_done,
    input  logic [ACB_W-1:0] period,
    output logic             ac
);

    typedef struct packed {
        logic [ACB_W-1:0] cnt;
        logic             ac;
    } acb_t;

    acb_t st_q, st_d;

    always_comb begin
        st_d = st_q;
        if (line_done) begin
            if (st_q.cnt >= period) begin
                st_d.cnt = '0;
                st_d.ac  = ~st_q.ac;
            end else begin
                st_d.cnt = st_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign ac = st_q.ac;

    assert_acb_on_line_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(st_q.ac) |-> $past(line_done));

endmodule

// File: rtl/lcd_raster_timer.sv
module lcd_raster_timer
    import lcd_raster_pkg::*;
#(
    parameter int H_W   = 10,
    parameter int V_W   = 10,
    parameter int ACB_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pix_rise,
    input  logic             pix_fall,
    input  logic [H_W-1:0]   cfg_hs_len,
    input  logic [H_W-1:0]   cfg_hb_len,
    input  logic [H_W-1:0]   cfg_ha_len,
    input  logic [H_W-1:0]   cfg_hf_len,
    input  logic [V_W-1:0]   cfg_vs_len,
    input  logic [V_W-1:0]   cfg_vb_len,
    input  logic [V_W-1:0]   cfg_va_len,
    input  logic [V_W-1:0]   cfg_vf_len,
    input  logic [ACB_W-1:0] cfg_acb_len,
    input  logic             hs_on_fall,
    input  logic             vs_on_fall,
    input  logic             hs_invert,
    input  logic             vs_invert,
    output logic             hsync,
    output logic             vsync,
    output logic             ac_bias,
    output logic             de,
    output logic             pix_req,
    output logic [H_W-1:0]   col,
    output logic [V_W-1:0]   row
);

    typedef struct packed {
        logic [H_W-1:0]   hs;
        logic [H_W-1:0]   hb;
        logic [H_W-1:0]   ha;
        logic [H_W-1:0]   hf;
        logic [V_W-1:0]   vs;
        logic [V_W-1:0]   vb;
        logic [V_W-1:0]   va;
        logic [V_W-1:0]   vf;
        logic [ACB_W-1:0] acb;
    } shadow_t;

    typedef struct packed {
        logic           fresh;
        shadow_t        cfg;
        logic           de;
        logic [H_W-1:0] col;
        logic [V_W-1:0] row;
        logic           req;
    } top_t;

    top_t    r_q, r_d;
    shadow_t live_cfg;

    seg_e           h_seg_q, h_seg_d, v_seg_q, v_seg_d;
    logic [H_W-1:0] h_idx_d;
    logic [V_W-1:0] v_idx_d;
    logic           h_last, v_last;
    logic           step, line_step, frame_wrap, act_next;

    assign step       = pix_rise && !r_q.fresh;
    assign line_step  = step && h_last;
    assign frame_wrap = line_step && v_last;

    lcd_axis_seq #(.W(H_W)) u_hpos (
        .clk       (clk),
        .rst_n     (rst_n),
        .step      (step),
        .len_sync  (r_q.cfg.hs),
        .len_back  (r_q.cfg.hb),
        .len_show  (r_q.cfg.ha),
        .len_front (r_q.cfg.hf),
        .seg_q     (h_seg_q),
        .seg_d     (h_seg_d),
        .idx_d     (h_idx_d),
        .last      (h_last)
    );

    lcd_axis_seq #(.W(V_W)) u_vpos (
        .clk       (clk),
        .rst_n     (rst_n),
        .step      (line_step),
        .len_sync  (r_q.cfg.vs),
        .len_back  (r_q.cfg.vb),
        .len_show  (r_q.cfg.va),
        .len_front (r_q.cfg.vf),
        .seg_q     (v_seg_q),
        .seg_d     (v_seg_d),
        .idx_d     (v_idx_d),
        .last      (v_last)
    );

    lcd_sync_launch u_hs (
        .clk      (clk),
        .rst_n    (rst_n),
        .rise     (pix_rise),
        .fall     (pix_fall && !r_q.fresh),
        .on_fall  (hs_on_fall),
        .invert   (hs_invert),
        .lvl_next (h_seg_d == SEG_SYNC),
        .lvl_now  (h_seg_q == SEG_SYNC),
        .sync     (hsync)
    );

    lcd_sync_launch u_vs (
        .clk      (clk),
        .rst_n    (rst_n),
        .rise     (pix_rise),
        .fall     (pix_fall && !r_q.fresh),
        .on_fall  (vs_on_fall),
        .invert   (vs_invert),
        .lvl_next (v_seg_d == SEG_SYNC),
        .lvl_now  (v_seg_q == SEG_SYNC),
        .sync     (vsync)
    );

    lcd_acb_toggle #(.ACB_W(ACB_W)) u_acb (
        .clk       (clk),
        .rst_n     (rst_n),
        .line_done (line_step),
        .period    (r_q.cfg.acb),
        .ac        (ac_bias)
    );

    always_comb begin
        live_cfg = '{hs: cfg_hs_len, hb: cfg_hb_len, ha: cfg_ha_len, hf: cfg_hf_len,
                     vs: cfg_vs_len, vb: cfg_vb_len, va: cfg_va_len, vf: cfg_vf_len,
                     acb: cfg_acb_len};
        act_next = (h_seg_d == SEG_SHOW) && (v_seg_d == SEG_SHOW);

        r_d     = r_q;
        r_d.req = 1'b0;
        if (r_q.fresh || frame_wrap) begin
            r_d.cfg = live_cfg;
        end
        if (pix_rise) begin
            r_d.fresh = 1'b0;
            r_d.de    = act_next;
            r_d.col   = act_next ? h_idx_d : '0;
            r_d.row   = act_next ? v_idx_d : '0;
            r_d.req   = act_next;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q       <= '0;
            r_q.fresh <= 1'b1;
        end else begin
            r_q <= r_d;
        end
    end

    assign de      = r_q.de;
    assign col     = r_q.col;
    assign row     = r_q.row;
    assign pix_req = r_q.req;

    assert_req_in_active_R5: assert property (@(posedge clk) disable iff (!rst_n)
        r_q.req |-> r_q.de);

    assert_idle_origin_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !r_q.de |-> (r_q.col == '0) && (r_q.row == '0));

    assert_cfg_frame_only_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(r_q.cfg) |-> $past(r_q.fresh || frame_wrap));

endmodule

// File: tb/sim_lcd_raster_timer.sv
module sim_lcd_raster_timer;

    localparam int CLK_PERIOD = 10;
    localparam int H_W   = 10;
    localparam int V_W   = 10;
    localparam int ACB_W = 8;

    typedef struct {
        int hs, hb, ha, hf, vs, vb, va, vf, acb;
    } tcfg_t;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             pix_rise = 1'b0, pix_fall = 1'b0;
    logic [H_W-1:0]   cfg_hs_len = '0, cfg_hb_len = '0, cfg_ha_len = '0, cfg_hf_len = '0;
    logic [V_W-1:0]   cfg_vs_len = '0, cfg_vb_len = '0, cfg_va_len = '0, cfg_vf_len = '0;
    logic [ACB_W-1:0] cfg_acb_len = '0;
    logic             hs_on_fall = 1'b0, vs_on_fall = 1'b0, hs_invert = 1'b0, vs_invert = 1'b0;
    logic             hsync, vsync, ac_bias, de, pix_req;
    logic [H_W-1:0]   col;
    logic [V_W-1:0]   row;

    int n_vec = 0;
    int n_bad = 0;
    bit done  = 0;

    // Reference position state
    tcfg_t cur, nxt;
    int    k, base, gl_line;
    bit    check_ac;
    int    prev_hs, prev_vs;

    always #(CLK_PERIOD/2) clk = ~clk;

    lcd_raster_timer #(.H_W(H_W), .V_W(V_W), .ACB_W(ACB_W)) u0 (
        .clk(clk), .rst_n(rst_n), .pix_rise(pix_rise), .pix_fall(pix_fall),
        .cfg_hs_len(cfg_hs_len), .cfg_hb_len(cfg_hb_len), .cfg_ha_len(cfg_ha_len),
        .cfg_hf_len(cfg_hf_len), .cfg_vs_len(cfg_vs_len), .cfg_vb_len(cfg_vb_len),
        .cfg_va_len(cfg_va_len), .cfg_vf_len(cfg_vf_len), .cfg_acb_len(cfg_acb_len),
        .hs_on_fall(hs_on_fall), .vs_on_fall(vs_on_fall),
        .hs_invert(hs_invert), .vs_invert(vs_invert),
        .hsync(hsync), .vsync(vsync), .ac_bias(ac_bias), .de(de), .pix_req(pix_req),
        .col(col), .row(row)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_vec++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s at pixel %0d: actual %0d expected %0d", req, what, k, act, exp);
        end
    endtask

    function automatic int line_len(input tcfg_t c);
        return c.hs + c.hb + c.ha + c.hf + 4;
    endfunction

    function automatic int frame_len(input tcfg_t c);
        return line_len(c) * (c.vs + c.vb + c.va + c.vf + 4);
    endfunction

    task automatic drive_cfg(input tcfg_t c);
        cfg_hs_len  = H_W'(c.hs);  cfg_hb_len = H_W'(c.hb);
        cfg_ha_len  = H_W'(c.ha);  cfg_hf_len = H_W'(c.hf);
        cfg_vs_len  = V_W'(c.vs);  cfg_vb_len = V_W'(c.vb);
        cfg_va_len  = V_W'(c.va);  cfg_vf_len = V_W'(c.vf);
        cfg_acb_len = ACB_W'(c.acb);
    endtask

    task automatic do_reset(input tcfg_t c);
        @(negedge clk);
        rst_n = 1'b0;
        drive_cfg(c);
        cur = c; nxt = c;
        k = 0; base = 0; gl_line = 0; prev_hs = 0; prev_vs = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    // One pixel: rising strobe, sample, falling strobe, sample.
    task automatic px();
        int kk, L, h, ln, e_hs, e_vs, e_de, e_col, e_row, hact, vact;
        kk = k - base;
        if (kk == frame_len(cur)) begin
            base = k; cur = nxt; kk = 0;
        end
        L  = line_len(cur);
        h  = kk % L;
        ln = kk / L;
        if (h == 0 && k > 0) gl_line++;
        e_hs = (h < cur.hs + 1) ? 1 : 0;
        e_vs = (ln < cur.vs + 1) ? 1 : 0;
        hact = (h >= cur.hs + cur.hb + 2) && (h < cur.hs + cur.hb + cur.ha + 3);
        vact = (ln >= cur.vs + cur.vb + 2) && (ln < cur.vs + cur.vb + cur.va + 3);
        e_de  = (hact && vact) ? 1 : 0;
        e_col = e_de ? h - (cur.hs + cur.hb + 2) : 0;
        e_row = e_de ? ln - (cur.vs + cur.vb + 2) : 0;

        pix_rise = 1'b1;
        @(negedge clk);
        pix_rise = 1'b0;
        // R6: rise-launched syncs update now; fall-launched keep previous level
        chk("R6", "hsync after rise", int'(hsync), (hs_on_fall ? prev_hs : e_hs) ^ int'(hs_invert));
        chk("R6", "vsync after rise", int'(vsync), (vs_on_fall ? prev_vs : e_vs) ^ int'(vs_invert));
        chk("R4", "de", int'(de), e_de);
        chk("R4", "col", int'(col), e_col);
        chk("R4", "row", int'(row), e_row);
        chk("R5", "pix_req pulse", int'(pix_req), e_de);
        if (check_ac) chk("R8", "ac_bias", int'(ac_bias), (gl_line / (cur.acb + 1)) % 2);
        pix_fall = 1'b1;
        @(negedge clk);
        pix_fall = 1'b0;
        // R2/R3: segment-derived sync levels hold after the falling strobe in every mode
        chk("R2", "hsync level", int'(hsync), e_hs ^ int'(hs_invert));
        chk("R3", "vsync level", int'(vsync), e_vs ^ int'(vs_invert));
        chk("R5", "pix_req one clock", int'(pix_req), 0);
        @(negedge clk);
        prev_hs = e_hs; prev_vs = e_vs;
        k++;
    endtask

    task automatic run_px(input int n);
        for (int i = 0; i < n; i++) px();
    endtask

    task automatic t_reset_state();
        tcfg_t c = '{1, 0, 3, 1, 0, 1, 2, 0, 0};
        hs_on_fall = 0; vs_on_fall = 0; hs_invert = 0; vs_invert = 0;
        do_reset(c);
        chk("R1", "hsync reset", int'(hsync), 0);
        chk("R1", "vsync reset", int'(vsync), 0);
        chk("R1", "de reset", int'(de), 0);
        chk("R1", "pix_req reset", int'(pix_req), 0);
        chk("R1", "ac_bias reset", int'(ac_bias), 0);
        chk("R1", "col reset", int'(col), 0);
        chk("R1", "row reset", int'(row), 0);
    endtask

    task automatic t_basic_rise();
        tcfg_t c = '{1, 0, 3, 1, 0, 1, 2, 0, 0};
        hs_on_fall = 0; vs_on_fall = 0; hs_invert = 0; vs_invert = 0;
        check_ac = 1;
        do_reset(c);
        run_px(130);
    endtask

    task automatic t_min_fields_mixed_edges();
        tcfg_t c = '{0, 0, 0, 0, 1, 0, 1, 0, 2};
        hs_on_fall = 0; vs_on_fall = 1; hs_invert = 1; vs_invert = 0;
        check_ac = 1;
        do_reset(c);
        run_px(60);
    endtask

    task automatic t_midframe_update();
        tcfg_t a = '{1, 0, 3, 1, 0, 1, 2, 0, 0};
        tcfg_t b = '{0, 1, 2, 0, 1, 0, 1, 1, 0};
        hs_on_fall = 1; vs_on_fall = 0; hs_invert = 0; vs_invert = 1;
        check_ac = 0;
        do_reset(a);
        run_px(20);
        drive_cfg(b);      // R9: must not take effect before pixel 63
        nxt = b;
        run_px(43 + 49 + 10);
    endtask

    task automatic t_hold_and_polarity();
        tcfg_t c = '{1, 0, 3, 1, 0, 1, 2, 0, 1};
        int s_hs, s_vs, s_de, s_col, s_row, s_ac;
        hs_on_fall = 0; vs_on_fall = 0; hs_invert = 0; vs_invert = 0;
        check_ac = 1;
        do_reset(c);
        run_px(31);        // lands inside the active area
        s_hs = hsync; s_vs = vsync; s_de = de; s_col = col; s_row = row; s_ac = ac_bias;
        repeat (20) @(negedge clk);
        for (int i = 0; i < 4; i++) begin
            pix_fall = 1'b1; @(negedge clk); pix_fall = 1'b0; @(negedge clk);
        end
        chk("R10", "hsync held", int'(hsync), s_hs);
        chk("R10", "vsync held", int'(vsync), s_vs);
        chk("R10", "de held", int'(de), s_de);
        chk("R10", "col held", int'(col), s_col);
        chk("R10", "row held", int'(row), s_row);
        chk("R10", "ac held", int'(ac_bias), s_ac);
        vs_invert = 1'b1;
        #1;
        chk("R7", "vsync immediate invert", int'(vsync), 1 - s_vs);
        hs_invert = 1'b1;
        #1;
        chk("R7", "hsync immediate invert", int'(hsync), 1 - s_hs);
        run_px(50);        // position resumes exactly where it stopped (R10)
    endtask

    initial begin
        t_reset_state();
        t_basic_rise();
        t_min_fields_mixed_edges();
        t_midframe_update();
        t_hold_and_polarity();
        if (!done) begin
            done = 1;
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_vec++;
            n_bad++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

endmodule